// File: doc/BRIEF.md
# Two-Requester Memory Slice Arbiter

This block decides which of two masters may use one memory slice: a DMA-side master and a system-bus master. Each master raises a request and holds it for as long as it wants the slice. It may also pulse an end-of-transfer strobe while still requesting. The arbiter answers with one grant per master. A grant stays asserted for the whole transfer. The policy is chosen at run time by a mode input. When the mode is 1, round robin is used. When the mode is 0, fixed priority is used, and each master's level comes from its own 2-bit priority input. The configuration register that holds these values lives outside the block: the mode bit resets to 1 there and the priority fields reset to 0.

A chip with two memory slices instantiates the block twice. Each copy gets its own mode and priority inputs. Grants are registered: a request seen at a clock edge can be granted in the next cycle at the earliest. The reset input is asynchronous and active low. Its release is synchronised inside the block, which takes two clock edges.

Top module: `mem_slice_arbiter`

## Requirements
- R1: After reset both grant outputs are low, and they stay low until a request is sampled.
- R2: At most one grant output is high in any cycle.
- R3: A grant rises only in the cycle after an edge at which the same master's request was high.
- R4: Fixed mode (mode input 0), no grant held, both requesting: the master with the numerically higher priority input is granted in the next cycle.
- R5: Fixed mode, no grant held, both requesting with equal priority values: the DMA-side master is granted.
- R6: Round-robin mode (mode input 1), no grant held, both requesting: the master not granted most recently is granted. After reset the system-bus master counts as most recently granted, so the DMA-side master wins the first contest.
- R7: A grant stays high while its master keeps requesting and does not assert end of transfer.
- R8: A grant falls at the edge where its master has request low or end of transfer high. The end-of-transfer input of a master that holds no grant has no effect.
- R9: At a release edge, a request from the other master that is high is granted in the next cycle, whatever the policy. Otherwise no grant is issued in that cycle.
- R10: Changing the mode or the priority inputs while a grant is held never removes or moves that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_dma | input | 1 | DMA-side master request |
| req_sys | input | 1 | System-bus master request |
| done_dma | input | 1 | DMA-side end of transfer |
| done_sys | input | 1 | System-bus end of transfer |
| rr_mode | input | 1 | 1 = round robin, 0 = fixed priority |
| prio_dma | input | PRIO_W | DMA-side priority level (fixed mode) |
| prio_sys | input | PRIO_W | System-bus priority level (fixed mode) |
| gnt_dma | output | 1 | Grant to DMA-side master |
| gnt_sys | output | 1 | Grant to system-bus master |

## Verification
The key collision is a release and a new decision landing on the same edge. One master drops its request or strobes end of transfer while the other is waiting, and sometimes the mode or priority inputs change on that same edge. Directed sequences set up the handoff with the waiting master's priority set higher, equal and lower. Long random runs with frequent configuration changes provoke the same collision many more times. At every cycle the grants are judged against a bench model built from the requirements. The model gives the handoff precedence over any policy decision and leaves a held grant alone.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_REQ = 2;
  localparam int OWN_W   = $clog2(NUM_REQ + 1);

  typedef enum logic [OWN_W-1:0] {
    OWN_NONE = 2'd0,
    OWN_DMA  = 2'd1,
    OWN_SYS  = 2'd2
  } owner_e;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int PRIO_W = 2
) (
  input  logic              req_dma,
  input  logic              req_sys,
  input  logic              rr_mode,
  input  logic [PRIO_W-1:0] prio_dma,
  input  logic [PRIO_W-1:0] prio_sys,
  input  logic              last_sys,
  output owner_e            pick
);
  logic sys_wins_tie;

  always_comb begin
    if (rr_mode) sys_wins_tie = !last_sys;
    else         sys_wins_tie = (prio_sys > prio_dma);
  end

  always_comb begin
    unique case ({req_dma, req_sys})
      2'b10:   pick = OWN_DMA;
      2'b01:   pick = OWN_SYS;
      2'b11:   pick = sys_wins_tie ? OWN_SYS : OWN_DMA;
      default: pick = OWN_NONE;
    endcase
  end
endmodule

// File: rtl/arb_owner_ctl.sv
module arb_owner_ctl
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_dma,
  input  logic   req_sys,
  input  logic   done_dma,
  input  logic   done_sys,
  input  owner_e pick,
  output owner_e owner_q,
  output logic   last_sys_q
);
  owner_e owner_d;
  logic   last_sys_d;
  logic   owner_en;
  logic   last_en;
  logic   dma_keep;
  logic   sys_keep;

  assign dma_keep = req_dma && !done_dma;
  assign sys_keep = req_sys && !done_sys;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_DMA: begin
        if (!dma_keep) owner_d = req_sys ? OWN_SYS : OWN_NONE;
      end
      OWN_SYS: begin
        if (!sys_keep) owner_d = req_dma ? OWN_DMA : OWN_NONE;
      end
      default: owner_d = pick;
    endcase
  end

  assign owner_en   = (owner_d != owner_q);
  assign last_en    = owner_en && (owner_d != OWN_NONE);
  assign last_sys_d = (owner_d == OWN_SYS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q    <= OWN_NONE;
      last_sys_q <= 1'b1;
    end else begin
      if (owner_en) owner_q    <= owner_d;
      if (last_en)  last_sys_q <= last_sys_d;
    end
  end
endmodule

// File: rtl/mem_slice_arbiter.sv
module mem_slice_arbiter
  import arb_pkg::*;
#(
  parameter int PRIO_W     = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_dma,
  input  logic              req_sys,
  input  logic              done_dma,
  input  logic              done_sys,
  input  logic              rr_mode,
  input  logic [PRIO_W-1:0] prio_dma,
  input  logic [PRIO_W-1:0] prio_sys,
  output logic              gnt_dma,
  output logic              gnt_sys
);
  logic   rst_core_n;
  owner_e pick;
  owner_e owner_q;
  logic   last_sys_q;

  arb_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  arb_pick #(.PRIO_W(PRIO_W)) u_pick (
    .req_dma  (req_dma),
    .req_sys  (req_sys),
    .rr_mode  (rr_mode),
    .prio_dma (prio_dma),
    .prio_sys (prio_sys),
    .last_sys (last_sys_q),
    .pick     (pick)
  );

  arb_owner_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_dma    (req_dma),
    .req_sys    (req_sys),
    .done_dma   (done_dma),
    .done_sys   (done_sys),
    .pick       (pick),
    .owner_q    (owner_q),
    .last_sys_q (last_sys_q)
  );

  assign gnt_dma = (owner_q == OWN_DMA);
  assign gnt_sys = (owner_q == OWN_SYS);
endmodule

// File: rtl/arb_mem_chk.sv
module arb_mem_chk #(
  parameter int PRIO_W = 2
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              req_dma,
  input logic              req_sys,
  input logic              done_dma,
  input logic              done_sys,
  input logic              rr_mode,
  input logic [PRIO_W-1:0] prio_dma,
  input logic [PRIO_W-1:0] prio_sys,
  input logic              gnt_dma,
  input logic              gnt_sys
);
  logic idle_both;
  logic rel_dma;
  logic rel_sys;

  assign idle_both = !gnt_dma && !gnt_sys && req_dma && req_sys;
  assign rel_dma   = gnt_dma && (!req_dma || done_dma);
  assign rel_sys   = gnt_sys && (!req_sys || done_sys);

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(gnt_dma && gnt_sys));

  p_rise_dma_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(gnt_dma) |-> $past(req_dma));

  p_rise_sys_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(gnt_sys) |-> $past(req_sys));

  p_fixed_high_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idle_both && !rr_mode && (prio_sys > prio_dma)) |=> gnt_sys);

  p_fixed_tie_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idle_both && !rr_mode && (prio_sys == prio_dma)) |=> gnt_dma);

  p_hold_dma_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (gnt_dma && req_dma && !done_dma) |=> gnt_dma);

  p_hold_sys_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (gnt_sys && req_sys && !done_sys) |=> gnt_sys);

  p_release_dma_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    rel_dma |=> !gnt_dma);

  p_release_sys_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    rel_sys |=> !gnt_sys);

  p_handoff_sys_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rel_dma && req_sys) |=> gnt_sys);

  p_handoff_dma_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rel_sys && req_dma) |=> gnt_dma);

  p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (gnt_sys && req_sys && !done_sys && !$stable({rr_mode, prio_dma, prio_sys})) |=> gnt_sys);
endmodule

bind mem_slice_arbiter arb_mem_chk #(.PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/tb_mem_slice_arbiter.sv
module tb_mem_slice_arbiter;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_dma, req_sys, done_dma, done_sys, rr_mode;
  logic [PW-1:0] prio_dma, prio_sys;
  logic          gnt_dma, gnt_sys;

  int n_tests = 0;
  int n_fail  = 0;

  // model state: 0 none, 1 dma, 2 sys
  int    m_own;
  bit    m_last_sys;
  string m_tag;

  mem_slice_arbiter #(.PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .req_dma(req_dma), .req_sys(req_sys),
    .done_dma(done_dma), .done_sys(done_sys), .rr_mode(rr_mode),
    .prio_dma(prio_dma), .prio_sys(prio_sys),
    .gnt_dma(gnt_dma), .gnt_sys(gnt_sys)
  );

  always #4 clk = ~clk;

  function automatic int pick_next(input int own, input bit lsys);
    bit both = req_dma && req_sys;
    if (own == 1) begin
      if (req_dma && !done_dma) begin m_tag = rr_mode || prio_sys != prio_dma ? "R10" : "R7"; return 1; end
      m_tag = req_sys ? "R9" : "R8";
      return req_sys ? 2 : 0;
    end
    if (own == 2) begin
      if (req_sys && !done_sys) begin m_tag = "R7"; return 2; end
      m_tag = req_dma ? "R9" : "R8";
      return req_dma ? 1 : 0;
    end
    if (both) begin
      if (rr_mode) begin m_tag = "R6"; return lsys ? 1 : 2; end
      if (prio_sys == prio_dma) begin m_tag = "R5"; return 1; end
      m_tag = "R4";
      return (prio_sys > prio_dma) ? 2 : 1;
    end
    m_tag = "R3";
    if (req_dma) return 1;
    if (req_sys) return 2;
    return 0;
  endfunction

  task automatic check_now(input string tag);
    int act = gnt_dma ? (gnt_sys ? 3 : 1) : (gnt_sys ? 2 : 0);
    n_tests++;
    if (act != m_own) begin
      n_fail++;
      $display("FAIL %s: grants {dma,sys} code actual %0d expected %0d at %0t", tag, act, m_own, $time);
    end
    if (gnt_dma && gnt_sys) begin
      n_fail++;
      $display("FAIL R2: both grants high, actual 2 expected at most 1");
    end
  endtask

  // one cycle: check at negedge, apply inputs, advance model across posedge
  task automatic step(input bit rd, input bit rs, input bit dd, input bit ds,
                      input bit rr, input logic [PW-1:0] pd, input logic [PW-1:0] ps);
    int nxt;
    req_dma = rd; req_sys = rs; done_dma = dd; done_sys = ds;
    rr_mode = rr; prio_dma = pd; prio_sys = ps;
    nxt = pick_next(m_own, m_last_sys);
    if (nxt != 0 && nxt != m_own) m_last_sys = (nxt == 2);
    m_own = nxt;
    @(negedge clk);
    check_now(m_tag);
  endtask

  initial begin
    rst_n = 1'b0;
    req_dma = 0; req_sys = 0; done_dma = 0; done_sys = 0;
    rr_mode = 1; prio_dma = 0; prio_sys = 0;
    m_own = 0; m_last_sys = 1'b1;
    repeat (3) @(negedge clk);
    check_now("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_now("R1");

    // R6: round robin, first contest goes to DMA, then alternates
    step(1,1,0,0, 1,0,0);
    step(1,1,1,0, 1,0,0);   // DMA ends, sys waiting -> handoff R9
    step(0,1,0,0, 1,0,0);
    step(0,0,0,0, 1,0,0);   // sys drops -> R8
    step(1,1,0,0, 1,0,0);   // R6: last was sys -> DMA
    step(0,0,0,0, 1,0,0);
    // R4: fixed, sys higher
    step(1,1,0,0, 0,2'd1,2'd3);
    step(1,1,0,0, 0,2'd3,2'd0);  // R10: priorities flip mid-transfer
    step(1,1,0,0, 1,2'd3,2'd0);  // R10: mode flips mid-transfer
    step(0,0,0,0, 0,2'd0,2'd0);
    // R5: tie goes to DMA
    step(1,1,0,0, 0,2'd2,2'd2);
    step(0,1,0,0, 0,2'd0,2'd3);  // release by request drop with handoff
    step(0,0,0,1, 0,0,0);
    // R8: done of an ungranted master has no effect
    step(1,0,0,1, 0,0,0);
    step(1,0,0,1, 0,0,0);
    step(1,0,1,0, 0,0,0);        // done pulse releases DMA while it still requests
    step(1,0,0,0, 0,0,0);        // re-granted one cycle later
    step(0,0,0,0, 0,0,0);
    // R4: DMA higher
    step(1,1,0,0, 0,2'd3,2'd2);
    step(0,0,0,0, 0,0,0);

    // constrained random
    void'($urandom(32'h5EED_A11B));
    for (int i = 0; i < 4000; i++) begin
      bit rd = ($urandom_range(0,9) < 7);
      bit rs = ($urandom_range(0,9) < 7);
      bit dd = ($urandom_range(0,9) == 0);
      bit ds = ($urandom_range(0,9) == 0);
      bit rr = (i % 500 < 250) ? ($urandom_range(0,19) != 0) : ($urandom_range(0,19) == 0);
      logic [PW-1:0] pd = ($urandom_range(0,3) == 0) ? PW'($urandom) : prio_dma;
      logic [PW-1:0] ps = ($urandom_range(0,3) == 0) ? PW'($urandom) : prio_sys;
      step(rd, rs, dd, ds, rr, pd, ps);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule